// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block rewrites local bus addresses into a wide remote address space for a bus bridge. A local region starting at a fixed base is cut into a row of equal-size windows. Software picks one shared window size as a power of two (1 MiB shifted left by a 3-bit index) and gives each window a 64-bit remote base plus an enable flag. Each incoming local address is mapped to the remote base of the window it falls in, plus its offset inside that window.

Software programs the block through a simple register port with a write strobe and a read strobe. A global enable bit in a control word gates the whole translator. Any address that cannot be translated leaves the block unchanged, zero-extended to 64 bits, and a miss flag is raised. There are four such cases: translation is off, the window is not enabled, the address lies below the region, or the address lies beyond the last window.

Top module: `ob_xlat_win`

## Requirements
- R1: After reset the control word, the size index and every window word read as zero, so every window is disabled and translation is off.
- R2: The control word at offset 0x004 and both 32-bit words of each window read back exactly as written. For window n the low word is at 0x200 + 8*n and the high word at 0x204 + 8*n. The size register at offset 0x030 keeps only its low 3 bits, and bits 31:3 read as zero.
- R3: `reg_rdata` holds the value of the addressed register in the cycle after `reg_rd_en`. Reads of any offset outside the map return zero.
- R4: The window size is 2^(20+s) bytes, where s is the size index. The window number is (address − LOCAL_BASE) >> (20+s).
- R5: For a hit, the translated address is {high word, low word with bit 0 cleared} plus the address bits below the window size.
- R6: While control bit 1 is clear, every request misses: `rsp_miss` is 1 and `rsp_addr` equals the request address zero-extended to 64 bits.
- R7: A request that lands in a window whose low-word bit 0 is clear misses, and its address passes through unchanged.
- R8: A request below LOCAL_BASE, or at or beyond window NUM_WIN, misses, and its address passes through unchanged. Window NUM_WIN−1 still translates.
- R9: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. Requests may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_miss | output | 1 | Result was not translated |

## Verification
Translation results and register read data are both due exactly one clock after the stimulus. Register writes take effect for any request or read issued in a later cycle. The driver applies each stimulus on a falling edge. For a request, it pushes the expected address and miss flag into a queue at that same moment. A monitor samples on every falling edge and pops one expected item for each cycle in which `rsp_valid` is high. Read data is compared on the falling edge that follows the read strobe. After the last request, an empty queue with `rsp_valid` low confirms that no result went missing and none was produced without a request.

// File: rtl/oat_pkg.sv
package oat_pkg;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 12;
  parameter int LADDR_W   = 32;
  parameter int RADDR_W   = 64;
  parameter int SIZE_W    = 3;
  parameter int MIN_SHIFT = 20;
  parameter int EN_BIT    = 1;

  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h004;
  parameter logic [ADDR_W-1:0] SIZE_OFS = 12'h030;
  parameter logic [ADDR_W-1:0] WIN_OFS  = 12'h200;

  // log2 of the window size in bytes
  function automatic logic [5:0] win_shift(input logic [SIZE_W-1:0] s);
    return 6'(MIN_SHIFT) + {3'b000, s};
  endfunction

  // mask selecting the in-window offset bits
  function automatic logic [LADDR_W-1:0] win_mask(input logic [5:0] sh);
    return ~({LADDR_W{1'b1}} << sh);
  endfunction

  // remote base of a window: high word over low word, enable bit cleared
  function automatic logic [RADDR_W-1:0] win_base(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo[DATA_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/oat_regs.sv
module oat_regs
  import oat_pkg::*;
#(
  parameter int NUM_WIN = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            xlat_en,
  output logic [SIZE_W-1:0]               size_idx,
  output logic [NUM_WIN-1:0]              win_valid,
  output logic [NUM_WIN-1:0][RADDR_W-1:0] win_base_o
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(NUM_WIN * 8);

  logic [DATA_W-1:0]              ctrl_q;
  logic [SIZE_W-1:0]              size_q;
  logic [NUM_WIN-1:0][DATA_W-1:0] lo_q;
  logic [NUM_WIN-1:0][DATA_W-1:0] hi_q;

  logic [ADDR_W-1:0] win_off;
  logic              in_win;
  logic [IDX_W-1:0]  widx;
  logic              sel_hi;

  assign win_off = addr - WIN_OFS;
  assign in_win  = (addr >= WIN_OFS) && (win_off < WIN_SPAN);
  assign widx    = win_off[IDX_W+2:3];
  assign sel_hi  = win_off[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      if (addr == CTRL_OFS) ctrl_q <= wdata;
      if (addr == SIZE_OFS) size_q <= wdata[SIZE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (wr_en && in_win && (widx == IDX_W'(g))) begin
        if (sel_hi) hi_q[g] <= wdata;
        else        lo_q[g] <= wdata;
      end
    end
    assign win_valid[g]  = lo_q[g][0];
    assign win_base_o[g] = win_base(hi_q[g], lo_q[g]);
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == CTRL_OFS)      rd_mux = ctrl_q;
    else if (addr == SIZE_OFS) rd_mux = {{(DATA_W-SIZE_W){1'b0}}, size_q};
    else if (in_win)           rd_mux = sel_hi ? hi_q[widx] : lo_q[widx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign xlat_en  = ctrl_q[EN_BIT];
  assign size_idx = size_q;
endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
  import oat_pkg::*;
#(
  parameter int                 NUM_WIN    = 32,
  parameter logic [LADDR_W-1:0] LOCAL_BASE = 32'h4000_0000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [LADDR_W-1:0]              req_addr,
  input  logic                            xlat_en,
  input  logic [SIZE_W-1:0]               size_idx,
  input  logic [NUM_WIN-1:0]              win_valid,
  input  logic [NUM_WIN-1:0][RADDR_W-1:0] win_base_i,
  output logic                            rsp_valid,
  output logic [RADDR_W-1:0]              rsp_addr,
  output logic                            rsp_miss,
  output logic                            hit_now
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [LADDR_W-1:0] loc_off;
  logic [5:0]         shamt;
  logic [LADDR_W-1:0] idx_full;
  logic [IDX_W-1:0]   sel;
  logic               below, beyond;
  logic [RADDR_W-1:0] xlat_addr;

  assign loc_off   = req_addr - LOCAL_BASE;
  assign shamt     = win_shift(size_idx);
  assign idx_full  = loc_off >> shamt;
  assign sel       = idx_full[IDX_W-1:0];
  assign below     = req_addr < LOCAL_BASE;
  assign beyond    = idx_full >= LADDR_W'(NUM_WIN);
  assign hit_now   = xlat_en && !below && !beyond && win_valid[sel];
  assign xlat_addr = win_base_i[sel]
                   + {{(RADDR_W-LADDR_W){1'b0}}, loc_off & win_mask(shamt)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_miss <= !hit_now;
        rsp_addr <= hit_now ? xlat_addr
                            : {{(RADDR_W-LADDR_W){1'b0}}, req_addr};
      end
    end
  end
endmodule

// File: rtl/ob_xlat_win.sv
module ob_xlat_win
  import oat_pkg::*;
#(
  parameter int                 NUM_WIN    = 32,
  parameter logic [LADDR_W-1:0] LOCAL_BASE = 32'h4000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic [63:0] rsp_addr,
  output logic        rsp_miss
);
  logic                            xlat_en;
  logic [SIZE_W-1:0]               size_idx;
  logic [NUM_WIN-1:0]              win_valid;
  logic [NUM_WIN-1:0][RADDR_W-1:0] win_base_w;
  logic                            hit_now;

  oat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .xlat_en    (xlat_en),
    .size_idx   (size_idx),
    .win_valid  (win_valid),
    .win_base_o (win_base_w)
  );

  oat_xlate #(.NUM_WIN(NUM_WIN), .LOCAL_BASE(LOCAL_BASE)) u_xlate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .xlat_en    (xlat_en),
    .size_idx   (size_idx),
    .win_valid  (win_valid),
    .win_base_i (win_base_w),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_miss   (rsp_miss),
    .hit_now    (hit_now)
  );
endmodule

// File: rtl/oat_chk.sv
module oat_chk
  import oat_pkg::*;
#(
  parameter logic [LADDR_W-1:0] LOCAL_BASE = 32'h4000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic [63:0] rsp_addr,
  input logic        rsp_miss,
  input logic        reg_rd_en,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic        xlat_en,
  input logic        hit_now
);
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_disabled_misses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_en) |=> rsp_miss);

  assert_below_region_misses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr < LOCAL_BASE)) |=> rsp_miss);

  assert_miss_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_now) |=> (rsp_addr == {32'h0, $past(req_addr)}));

  assert_size_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (reg_addr == SIZE_OFS)) |=> (reg_rdata[31:SIZE_W] == '0));
endmodule

bind ob_xlat_win oat_chk #(.LOCAL_BASE(LOCAL_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_miss  (rsp_miss),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .xlat_en   (xlat_en),
  .hit_now   (hit_now)
);

// File: tb/ob_xlat_win_bench.sv
module ob_xlat_win_bench;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        rsp_miss;

  always #2 clk = ~clk;

  ob_xlat_win u_ob_xlat_win (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] a;
    logic        m;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // shadow of programmed state
  logic [31:0] m_ctrl = '0;
  logic [2:0]  m_size = '0;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 12'h004) m_ctrl = d;
    if (a == 12'h030) m_size = d[2:0];
    if (a >= 12'h200 && a < 12'h300) begin
      if (a[2]) m_hi[(a - 12'h200) >> 3] = d;
      else      m_lo[(a - 12'h200) >> 3] = d;
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(reg_rdata == exp, tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    longint unsigned off, idx, span;
    e.tag = tag;
    e.a = {32'h0, a};
    e.m = 1'b1;
    if (m_ctrl[1] && a >= BASE) begin
      off  = longint'(a - BASE);
      span = 64'd1 << (20 + int'(m_size));
      idx  = off / span;
      if (idx < 32 && m_lo[idx][0]) begin
        e.m = 1'b0;
        e.a = ({m_hi[idx], m_lo[idx]} & ~64'd1) + (off % span);
      end
    end
    return e;
  endfunction

  // leaves req_valid high; caller ends the burst with idle()
  task automatic send(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    sb.push_back(model(a, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send1(input logic [31:0] a, input string tag);
    send(a, tag);
    idle();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_addr, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_addr == e.a, {e.tag, " addr"}, rsp_addr, e.a);
        check(rsp_miss == e.m, {e.tag, " miss"}, {63'h0, rsp_miss}, {63'h0, e.m});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    rd(12'h004, 32'h0, "R1 ctrl reset");
    rd(12'h030, 32'h0, "R1 size reset");
    rd(12'h228, 32'h0, "R1 window 5 low reset");
    send1(BASE + 32'h10, "R1 request after reset misses");

    // R2: readback
    wr(12'h004, 32'h0000_0005);
    rd(12'h004, 32'h0000_0005, "R2 ctrl readback");
    wr(12'h030, 32'hFFFF_FFFB);
    rd(12'h030, 32'h0000_0003, "R2 size keeps low 3 bits");
    wr(12'h030, 32'h0);

    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0001);
    wr(12'h208, 32'h1230_0001); wr(12'h20C, 32'h0000_0000);
    wr(12'h210, 32'h5550_0000); wr(12'h214, 32'h0000_0007);
    wr(12'h2F8, 32'hABC0_0001); wr(12'h2FC, 32'hFFFF_0000);
    rd(12'h2FC, 32'hFFFF_0000, "R2 window 31 high readback");
    rd(12'h208, 32'h1230_0001, "R2 window 1 low readback");

    // R3: unmapped read
    rd(12'h100, 32'h0, "R3 unmapped read");
    rd(12'h300, 32'h0, "R3 read past last window");

    // R6: enable clear
    send1(BASE + 32'h0001_2345, "R6 disabled passthrough");

    // read-modify-write to set enable
    rd(12'h004, 32'h0000_0005, "R2 ctrl before enable");
    wr(12'h004, 32'h0000_0007);
    rd(12'h004, 32'h0000_0007, "R2 ctrl keeps other bits");

    // R5 / R9: back-to-back burst with size index 0
    send(BASE + 32'h0001_2345, "R5 window 0");
    send(BASE + 32'h0010_0010, "R5 window 1");
    send(BASE + 32'h0020_0000, "R7 disabled window 2");
    send(BASE + 32'h01F0_0004, "R8 last window translates");
    send(BASE + 32'h0200_0000, "R8 beyond last window");
    send(BASE - 32'h4, "R8 below region");
    idle();

    // R4: size index 2 gives 4 MiB windows
    wr(12'h030, 32'h2);
    send(BASE + 32'h003F_FFFF, "R4 top of window 0");
    send(BASE + 32'h0040_0008, "R4 start of window 1");
    send(BASE + 32'h07C0_0000, "R4 window 31");
    send(BASE + 32'h0800_0000, "R4 beyond span");
    idle();

    // R7: disable a window through bit 0 and retry it
    wr(12'h208, 32'h1230_0000);
    send1(BASE + 32'h0040_0008, "R7 window 1 disabled");

    // R6 again: enable cleared while other bits kept
    wr(12'h004, 32'h0000_0005);
    send1(BASE + 32'h0000_0100, "R6 disabled again");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9 all responses received", 64'(sb.size()), 64'h0);
    check(rsp_valid == 1'b0, "R9 no response when idle", {63'h0, rsp_valid}, 64'h0);
    finish_run();
  end
endmodule